// File: doc/BRIEF.md
# Adaptive Delta Nibble Decoder

This block turns a stream of 4-bit adaptive delta codes into signed 16-bit audio samples, consuming one code per valid strobe. It holds two pieces of state: a signed running sample (the accumulator) and an unsigned adaptive step size. Each accepted code moves the accumulator by an odd multiple of one eighth of the step, in the direction given by the code's sign bit. The code's magnitude also rescales the step by a factor in units of 1/64. Both results are saturated, each to its own range.

The block sits between a code source, such as a memory fetcher or a host write path, and later sample-rate and mixing stages. Those stages are outside this block. A restart pulse returns the decoder to its starting state at the head of a new clip. The previous sample is kept as a separate output so that a downstream interpolator can blend the last two values.

Top module: `adpcm_nib_dec`

## Requirements
- R1: After reset, and in the cycle after a restart pulse, sample_o = 0, prev_o = 0 and step_o = 127.
- R2: When restart_i and code_vld_i are both high in one cycle, the restart takes effect and the code is discarded: the outputs show the R1 values one cycle later.
- R3: On every accepted code, prev_o takes the value sample_o held before the update.
- R4: Code bit 3 is the sign (1 = subtract) and bits 2..0 are the magnitude m. The accumulator changes by (2m+1)*step/8, truncated toward zero, and is added when bit 3 is 0 and subtracted when bit 3 is 1.
- R5: The new step is step*F/64, truncated, with F = 57 for m = 0..3, 77 for m = 4, 102 for m = 5, 128 for m = 6 and 153 for m = 7. The sign bit has no effect on F.
- R6: The accumulator saturates to the range -32768 to +32767 after every update.
- R7: The step saturates to the range 127 to 24576 after every update.
- R8: In a cycle with neither restart_i nor code_vld_i high, all three outputs keep their values.
- R9: Outputs are registered: the result of a code presented with code_vld_i at clock edge k is visible after edge k, with no further delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous return to the starting state |
| code_vld_i | input | 1 | Accept code_i on this edge |
| code_i | input | 4 | Delta code: bit 3 sign, bits 2..0 magnitude |
| sample_o | output | 16 | Current decoded sample, signed |
| prev_o | output | 16 | Sample before the last update, signed |
| step_o | output | 15 | Current adaptive step size |

## Verification
The bench uses the default parameters: a 16-bit sample, a 15-bit step, and step limits of 127 and 24576. With these values, a run of largest-magnitude codes pushes the step to its ceiling in seven updates, and within a few more codes it drives the accumulator into both rails. A long run of zero codes lets the step decay to its floor. A pseudo-random code stream with gaps in the strobe, rare restarts and one restart that coincides with a strobe then covers rounding, the sign-independent step factor and the hold behaviour, all checked against an integer model of the requirements.

// File: rtl/adpcm_nib_pkg.sv
package adpcm_nib_pkg;

  typedef logic [3:0] nib_t;

  // odd accumulator multiplier 2m+1, in eighths of the step
  function automatic logic [3:0] odd_mult(input logic [2:0] mag);
    return {mag, 1'b1};
  endfunction

  // step adaptation factor in 64ths, shared by both signs
  function automatic logic [7:0] adapt_mult(input logic [2:0] mag);
    logic [7:0] f;
    case (mag)
      3'd4:    f = 8'd77;
      3'd5:    f = 8'd102;
      3'd6:    f = 8'd128;
      3'd7:    f = 8'd153;
      default: f = 8'd57;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/adpcm_acc_upd.sv
module adpcm_acc_upd
  import adpcm_nib_pkg::*;
#(
  parameter int SAMP_W = 16,
  parameter int STEP_W = 15
) (
  input  logic signed [SAMP_W-1:0] acc_i,
  input  logic        [STEP_W-1:0] step_i,
  input  nib_t                     code_i,
  output logic signed [SAMP_W-1:0] acc_o,
  output logic                     sat_o
);
  localparam int PROD_W = STEP_W + 4;
  localparam int SUM_W  = ((SAMP_W > PROD_W) ? SAMP_W : PROD_W) + 2;

  localparam logic signed [SUM_W-1:0] LIM_HI =
    {{(SUM_W-SAMP_W+1){1'b0}}, {(SAMP_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LIM_LO = -LIM_HI - 1;

  // unsigned increment magnitude, truncated; sign applied afterwards
  function automatic logic [PROD_W-1:0] inc_mag(input nib_t c, input logic [STEP_W-1:0] s);
    logic [PROD_W-1:0] p;
    p = PROD_W'(odd_mult(c[2:0])) * PROD_W'(s);
    return p >> 3;
  endfunction

  logic signed [SUM_W-1:0] acc_ext, inc_ext, sum;

  always_comb begin
    acc_ext = $signed({{(SUM_W-SAMP_W){acc_i[SAMP_W-1]}}, acc_i});
    inc_ext = $signed({{(SUM_W-PROD_W){1'b0}}, inc_mag(code_i, step_i)});
    sum     = code_i[3] ? (acc_ext - inc_ext) : (acc_ext + inc_ext);
    sat_o   = 1'b0;
    if (sum > LIM_HI) begin
      acc_o = LIM_HI[SAMP_W-1:0];
      sat_o = 1'b1;
    end else if (sum < LIM_LO) begin
      acc_o = LIM_LO[SAMP_W-1:0];
      sat_o = 1'b1;
    end else begin
      acc_o = sum[SAMP_W-1:0];
    end
  end
endmodule

// File: rtl/adpcm_step_upd.sv
module adpcm_step_upd
  import adpcm_nib_pkg::*;
#(
  parameter int STEP_W   = 15,
  parameter int STEP_MIN = 127,
  parameter int STEP_MAX = 24576
) (
  input  logic [STEP_W-1:0] step_i,
  input  nib_t              code_i,
  output logic [STEP_W-1:0] step_o
);
  localparam int PROD_W = STEP_W + 8;
  localparam logic [PROD_W-1:0] LO = PROD_W'(STEP_MIN);
  localparam logic [PROD_W-1:0] HI = PROD_W'(STEP_MAX);

  function automatic logic [PROD_W-1:0] scaled(input logic [STEP_W-1:0] s, input nib_t c);
    logic [PROD_W-1:0] p;
    p = PROD_W'(s) * PROD_W'(adapt_mult(c[2:0]));
    return p >> 6;
  endfunction

  logic [PROD_W-1:0] nxt;

  always_comb begin
    nxt = scaled(step_i, code_i);
    if (nxt > HI)      step_o = HI[STEP_W-1:0];
    else if (nxt < LO) step_o = LO[STEP_W-1:0];
    else               step_o = nxt[STEP_W-1:0];
  end
endmodule

// File: rtl/adpcm_nib_dec.sv
module adpcm_nib_dec
  import adpcm_nib_pkg::*;
#(
  parameter int SAMP_W    = 16,
  parameter int STEP_W    = 15,
  parameter int STEP_MIN  = 127,
  parameter int STEP_MAX  = 24576,
  parameter int STEP_INIT = 127
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     restart_i,
  input  logic                     code_vld_i,
  input  logic [3:0]               code_i,
  output logic signed [SAMP_W-1:0] sample_o,
  output logic signed [SAMP_W-1:0] prev_o,
  output logic        [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] STEP_RST = STEP_W'(STEP_INIT);

  // named events for the checks below
  logic rst_fire, upd_fire, acc_sat;
  assign rst_fire = restart_i;
  assign upd_fire = code_vld_i & ~restart_i;

  logic signed [SAMP_W-1:0] acc_nxt;
  logic        [STEP_W-1:0] step_nxt;

  adpcm_acc_upd #(.SAMP_W(SAMP_W), .STEP_W(STEP_W)) u_acc (
    .acc_i (sample_o),
    .step_i(step_o),
    .code_i(code_i),
    .acc_o (acc_nxt),
    .sat_o (acc_sat)
  );

  adpcm_step_upd #(.STEP_W(STEP_W), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_step (
    .step_i(step_o),
    .code_i(code_i),
    .step_o(step_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      prev_o   <= '0;
      step_o   <= STEP_RST;
    end else if (rst_fire) begin
      sample_o <= '0;
      prev_o   <= '0;
      step_o   <= STEP_RST;
    end else if (upd_fire) begin
      prev_o   <= sample_o;
      sample_o <= acc_nxt;
      step_o   <= step_nxt;
    end
  end

  // R1, R2: restart wins over a simultaneous code
  p_restart_state_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_fire |=> (sample_o == '0 && prev_o == '0 && step_o == STEP_RST));

  // R3: previous sample follows the accumulator by one update
  p_prev_follow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_fire |=> prev_o == $past(sample_o));

  // R4: a positive code never lowers the sample
  p_pos_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_fire && !code_i[3]) |=> sample_o >= $past(sample_o));

  // R4: a negative code never raises the sample
  p_neg_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_fire && code_i[3]) |=> sample_o <= $past(sample_o));

  // R7: step stays within its limits
  p_step_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o >= STEP_W'(STEP_MIN)) && (step_o <= STEP_W'(STEP_MAX)));

  // R8: idle cycles hold all state
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_vld_i && !restart_i) |=> ($stable(sample_o) && $stable(prev_o) && $stable(step_o)));

  // R6: a saturating update lands on a rail
  p_sat_rail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_fire && acc_sat) |=> (sample_o == {1'b0, {(SAMP_W-1){1'b1}}} ||
                               sample_o == {1'b1, {(SAMP_W-1){1'b0}}}));
endmodule

// File: tb/sim_adpcm_nib_dec.sv
module sim_adpcm_nib_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic vld = 1'b0;
  logic [3:0] code = 4'd0;
  logic signed [15:0] sample, prev;
  logic [14:0] step;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  int m_acc = 0, m_prev = 0, m_step = 127;
  string last_req = "R1";

  always #10 clk = ~clk;

  adpcm_nib_dec u0 (
    .clk_i(clk), .rst_ni(rst_n), .restart_i(restart), .code_vld_i(vld),
    .code_i(code), .sample_o(sample), .prev_o(prev), .step_o(step)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  // R4/R5/R6/R7 restated in integers
  function automatic void model_code(int c);
    int mag, d, f;
    mag = c % 8;
    d = ((2 * mag + 1) * m_step) / 8;
    if (c >= 8) d = -d;
    f = (mag <= 3) ? 57 : (mag == 4) ? 77 : (mag == 5) ? 102 : (mag == 6) ? 128 : 153;
    m_prev = m_acc;
    m_acc  = clampi(m_acc + d, -32768, 32767);
    m_step = clampi((m_step * f) / 64, 127, 24576);
  endfunction

  task automatic compare(string req);
    n_chk++;
    if (int'(sample) != m_acc || int'(step) != m_step) begin
      n_bad++;
      $display("FAIL %s sample=%0d step=%0d expected sample=%0d step=%0d",
               req, sample, step, m_acc, m_step);
    end
    n_chk++;
    if (int'(prev) != m_prev) begin
      n_bad++;
      $display("FAIL R3 (%s) prev=%0d expected %0d", req, prev, m_prev);
    end
  endtask

  // one cycle: compare result of last cycle (R9 timing), then apply new stimulus
  task automatic cyc(bit rs, bit v, int c, string req);
    @(negedge clk);
    compare(last_req);
    restart = rs;
    vld = v;
    code = 4'(c);
    if (rs) begin
      m_acc = 0; m_prev = 0; m_step = 127;
    end else if (v) begin
      model_code(c);
    end
    last_req = req;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, "R1");                       // reset state
    for (int i = 0; i < 12; i++) cyc(0, 1, 7, "R7"); // step ceiling, positive rail R6
    for (int i = 0; i < 4; i++) cyc(0, 0, 5, "R8");  // idle hold
    for (int i = 0; i < 14; i++) cyc(0, 1, 15, "R6"); // negative rail
    for (int i = 0; i < 60; i++) cyc(0, 1, 0, "R7");  // step decays to floor
    cyc(1, 0, 0, "R1");
    cyc(0, 1, 6, "R4");
    cyc(1, 1, 7, "R2");                        // restart with code: code dropped
    cyc(0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) begin          // sign does not change the factor
      cyc(0, 1, 3 + 8 * (i % 2), "R5");
      cyc(0, 1, 12 - (i % 2) * 8, "R5");
    end
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        cyc(lf[7:0] == 8'h3C, lf[9:8] != 2'b00, int'(lf[3:0]), "R4");
      end
    end
    cyc(0, 0, 0, "R8");
    cyc(0, 0, 0, "R8");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule